// File: doc/BRIEF.md
# Pin Bank Register Block with Per-Pin Masked Writes

This block holds the control state for one bank of general-purpose pins, split into several ports of eight pins each (four ports, 32 pins by default). Software reaches it over a plain 32-bit memory-mapped bus. Each port has three 8-bit control fields: a mode bit per pin, a drive-enable bit per pin and a drive-level bit per pin. A fourth field returns the synchronized pad level. The mode bit chooses who owns the pad. When it is set, the pad is driven from the block's own drive-enable and drive-level bits. When it is clear, an alternate function's drive signals are passed through to the pad.

Every writable field also appears at a second, masked address. A write there carries a pin-select byte and a value byte. Only the selected pins change, in a single bus cycle. Two agents can therefore update different pins of the same port without a read-modify-write race.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is held and after it is released, all control fields read zero. Every pin is then in alternate mode, and `pad_gpio_sel`, `pad_out` and `pad_oe` are zero during reset.
- R2: Address decode works as follows. `bus_addr[6:4]` selects the field: 0 mode, 1 drive-enable, 2 drive-level, 3 pad input. `bus_addr[3:2]` selects the port. `bus_addr[7]` selects the masked alias. `bus_addr[1:0]` is ignored. Read data carries the port's 8 bits in `bus_rdata[7:0]`, and the upper bits are zero.
- R3: A write to a plain address replaces the whole 8-bit field with `bus_wdata[7:0]`. Bits 31:8 are ignored.
- R4: A write to a masked address changes pin n only when `bus_wdata[8+n]` is 1, and that pin takes `bus_wdata[n]`. All other pins keep their value, so a zero select byte changes nothing.
- R5: Reading a masked address of the mode, drive-enable or drive-level field returns the same value as the plain address.
- R6: For a pin in GPIO mode, `pad_out` and `pad_oe` equal the pin's drive-level and drive-enable bits as they stood one cycle earlier.
- R7: For a pin in alternate mode, `pad_out` and `pad_oe` equal `alt_out` and `alt_oe` as they stood one cycle earlier, whatever the pin's own drive bits hold.
- R8: The pad-input field returns `pad_in` through a two-flop synchronizer, whatever the pin's direction. A read issued two clock edges after a pad change returns the new level. A read issued one edge after the change returns the old level.
- R9: Writes to the pad-input field, to its masked address, or to field codes 4 to 7 change no state. Reads of field codes 4 to 7 and of the masked pad-input address return zero.
- R10: `bus_rdata` is valid in the cycle after `bus_rd` is asserted, and it is zero in any cycle that does not follow a read.
- R11: A write to one port leaves every other port's fields unchanged.
- R12: `pad_gpio_sel` equals the mode bits delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data; masked writes use bits 15:8 as the select byte |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| alt_out | input | 32 | Alternate-function drive level |
| alt_oe | input | 32 | Alternate-function drive enable |
| pad_out | output | 32 | Registered pad drive level |
| pad_oe | output | 32 | Registered pad drive enable |
| pad_gpio_sel | output | 32 | Registered per-pin mode (1 = GPIO owns the pad) |

## Verification
The assertions check the following on every cycle:
- pad ownership for both modes against the one-cycle-old register or alternate values;
- that the mode output tracks the mode bits;
- that idle cycles give zero read data;
- that a zero-select masked write changes nothing;
- that writes to the input field or to undefined fields change nothing;
- the reset state.

The exact bit merge of a masked write, the address decode, alias read equality, port isolation and the synchronizer latency on `pad_in` are shown only by the bench's scenarios. The bench compares read-back values and pad levels against values worked out by hand.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // field codes carried in address bits [6:4]
  localparam logic [2:0] FLD_MODE  = 3'd0;
  localparam logic [2:0] FLD_DRVEN = 3'd1;
  localparam logic [2:0] FLD_LEVEL = 3'd2;
  localparam logic [2:0] FLD_PADIN = 3'd3;

  // number of writable fields per port
  localparam int NUM_WFIELDS = 3;

  // address bit positions
  localparam int ALIAS_BIT = 7;
  localparam int FLD_LSB   = 4;
  localparam int PORT_LSB  = 2;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PIN_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [gpio_bank_pkg::NUM_WFIELDS-1:0] wr_hit,
  input  logic                             masked,
  input  logic [2*PIN_W-1:0]               wdata,
  output logic [PIN_W-1:0]                 mode_q,
  output logic [PIN_W-1:0]                 drven_q,
  output logic [PIN_W-1:0]                 level_q
);
  localparam int NF = gpio_bank_pkg::NUM_WFIELDS;

  logic [PIN_W-1:0] fld_q [NF];
  logic [PIN_W-1:0] sel_bits;
  logic [PIN_W-1:0] new_bits;

  assign new_bits = wdata[PIN_W-1:0];
  assign sel_bits = masked ? wdata[2*PIN_W-1:PIN_W] : {PIN_W{1'b1}};

  for (genvar f = 0; f < NF; f++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst) begin
        fld_q[f] <= '0;
      end else if (wr_hit[f]) begin
        fld_q[f] <= (fld_q[f] & ~sel_bits) | (new_bits & sel_bits);
      end
    end
  end

  assign mode_q  = fld_q[0];
  assign drven_q = fld_q[1];
  assign level_q = fld_q[2];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] own_sel,
  input  logic [WIDTH-1:0] own_out,
  input  logic [WIDTH-1:0] own_oe,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_sel <= '0;
    end else begin
      pad_out <= (own_sel & own_out) | (~own_sel & alt_out);
      pad_oe  <= (own_sel & own_oe)  | (~own_sel & alt_oe);
      pad_sel <= own_sel;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int PORTS       = 4,
  parameter int PIN_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [PORTS*PIN_W-1:0] pad_in,
  input  logic [PORTS*PIN_W-1:0] alt_out,
  input  logic [PORTS*PIN_W-1:0] alt_oe,
  output logic [PORTS*PIN_W-1:0] pad_out,
  output logic [PORTS*PIN_W-1:0] pad_oe,
  output logic [PORTS*PIN_W-1:0] pad_gpio_sel
);
  import gpio_bank_pkg::*;

  localparam int PINS    = PORTS * PIN_W;
  localparam int PORT_AW = $clog2(PORTS);

  // address fields
  logic               alias_sel;
  logic [2:0]         fld;
  logic [PORT_AW-1:0] port_idx;

  assign alias_sel = bus_addr[ALIAS_BIT];
  assign fld       = bus_addr[FLD_LSB +: 3];
  assign port_idx  = bus_addr[PORT_LSB +: PORT_AW];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[PORT_LSB-1:0], bus_wdata[DATA_W-1:2*PIN_W]};

  // field hit, one bit per writable field
  logic [NUM_WFIELDS-1:0] fld_hit;
  always_comb begin
    fld_hit = '0;
    case (fld)
      FLD_MODE:  fld_hit[0] = 1'b1;
      FLD_DRVEN: fld_hit[1] = 1'b1;
      FLD_LEVEL: fld_hit[2] = 1'b1;
      default:   fld_hit = '0;
    endcase
  end

  logic [PIN_W-1:0] mode_p  [PORTS];
  logic [PIN_W-1:0] drven_p [PORTS];
  logic [PIN_W-1:0] level_p [PORTS];
  logic [PIN_W-1:0] padin_p [PORTS];

  logic [PINS-1:0] mode_all;
  logic [PINS-1:0] drven_all;
  logic [PINS-1:0] level_all;
  logic [PINS-1:0] padin_sync;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [NUM_WFIELDS-1:0] wr_hit_p;
    assign wr_hit_p = (bus_wr && (port_idx == PORT_AW'(p))) ? fld_hit : '0;

    gpio_port_regs #(.PIN_W(PIN_W)) u_port (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit_p),
      .masked  (alias_sel),
      .wdata   (bus_wdata[2*PIN_W-1:0]),
      .mode_q  (mode_p[p]),
      .drven_q (drven_p[p]),
      .level_q (level_p[p])
    );

    assign mode_all [p*PIN_W +: PIN_W] = mode_p[p];
    assign drven_all[p*PIN_W +: PIN_W] = drven_p[p];
    assign level_all[p*PIN_W +: PIN_W] = level_p[p];
    assign padin_p[p] = padin_sync[p*PIN_W +: PIN_W];
  end

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (padin_sync)
  );

  gpio_pad_mux #(.WIDTH(PINS)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .own_sel (mode_all),
    .own_out (level_all),
    .own_oe  (drven_all),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_sel (pad_gpio_sel)
  );

  // read path
  logic [PIN_W-1:0] rd_field;
  always_comb begin
    rd_field = '0;
    case (fld)
      FLD_MODE:  rd_field = mode_p[port_idx];
      FLD_DRVEN: rd_field = drven_p[port_idx];
      FLD_LEVEL: rd_field = level_p[port_idx];
      FLD_PADIN: rd_field = alias_sel ? '0 : padin_p[port_idx];
      default:   rd_field = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{(DATA_W-PIN_W){1'b0}}, rd_field};
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   alt_out,
  input logic [PINS-1:0]   alt_oe,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_gpio_sel,
  input logic [PINS-1:0]   mode_all,
  input logic [PINS-1:0]   drven_all,
  input logic [PINS-1:0]   level_all
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (mode_all == '0 && drven_all == '0 && level_all == '0 &&
             pad_gpio_sel == '0 && pad_out == '0 && pad_oe == '0));

  // R4
  zero_select_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[7] && bus_wdata[15:8] == 8'h00)
      |=> ($stable(mode_all) && $stable(drven_all) && $stable(level_all)));

  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[6:4] >= 3'd3)
      |=> ($stable(mode_all) && $stable(drven_all) && $stable(level_all)));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R6
  own_pad_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ((pad_out & pad_gpio_sel) == ($past(level_all) & pad_gpio_sel)) &&
    ((pad_oe  & pad_gpio_sel) == ($past(drven_all) & pad_gpio_sel)));

  // R7
  alt_pad_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ((pad_out & ~pad_gpio_sel) == ($past(alt_out) & ~pad_gpio_sel)) &&
    ((pad_oe  & ~pad_gpio_sel) == ($past(alt_oe)  & ~pad_gpio_sel)));

  // R12
  mode_out_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    pad_gpio_sel == $past(mode_all));
endmodule

bind gpio_bank_regs gpio_bank_chk #(
  .PINS   (PORTS * PIN_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .alt_out      (alt_out),
  .alt_oe       (alt_oe),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .pad_gpio_sel (pad_gpio_sel),
  .mode_all     (mode_all),
  .drven_all    (drven_all),
  .level_all    (level_all)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] alt_out = '0;
  logic [31:0] alt_oe = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [31:0] pad_gpio_sel;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_bank_regs i_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_gpio_sel(pad_gpio_sel)
  );

  // {is_read, req, addr, wdata, expected byte}
  localparam int NV = 30;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 4'd3,  8'h00, 32'h000000A5, 8'h00},  // R3 mode p0
    {1'b1, 4'd2,  8'h00, 32'h0,        8'hA5},  // R2
    {1'b1, 4'd5,  8'h80, 32'h0,        8'hA5},  // R5
    {1'b0, 4'd4,  8'h80, 32'h00000F0A, 8'h00},  // R4 low nibble
    {1'b1, 4'd4,  8'h00, 32'h0,        8'hAA},  // R4
    {1'b0, 4'd4,  8'h80, 32'h000000FF, 8'h00},  // R4 empty select
    {1'b1, 4'd4,  8'h00, 32'h0,        8'hAA},  // R4
    {1'b0, 4'd3,  8'h14, 32'h0000003C, 8'h00},  // R3 drive-enable p1
    {1'b1, 4'd2,  8'h14, 32'h0,        8'h3C},  // R2
    {1'b1, 4'd5,  8'h94, 32'h0,        8'h3C},  // R5
    {1'b1, 4'd11, 8'h10, 32'h0,        8'h00},  // R11 p0 untouched
    {1'b0, 4'd4,  8'h94, 32'h0000C3FF, 8'h00},  // R4
    {1'b1, 4'd4,  8'h14, 32'h0,        8'hFF},  // R4
    {1'b0, 4'd3,  8'h2C, 32'h12345678, 8'h00},  // R3 upper bits dropped
    {1'b1, 4'd3,  8'h2C, 32'h0,        8'h78},  // R3
    {1'b0, 4'd4,  8'hAC, 32'h00000101, 8'h00},  // R4 single pin
    {1'b1, 4'd5,  8'hAC, 32'h0,        8'h79},  // R5
    {1'b0, 4'd9,  8'h30, 32'h000000FF, 8'h00},  // R9 input write
    {1'b1, 4'd9,  8'h30, 32'h0,        8'h00},  // R9
    {1'b0, 4'd9,  8'h40, 32'h000000FF, 8'h00},  // R9 undefined field
    {1'b1, 4'd9,  8'h40, 32'h0,        8'h00},  // R9
    {1'b1, 4'd9,  8'hB0, 32'h0,        8'h00},  // R9 masked input alias
    {1'b0, 4'd9,  8'h7C, 32'h000000FF, 8'h00},  // R9
    {1'b1, 4'd9,  8'h7C, 32'h0,        8'h00},  // R9
    {1'b0, 4'd3,  8'h08, 32'h0000000F, 8'h00},  // R3
    {1'b0, 4'd3,  8'h08, 32'h000000F0, 8'h00},  // R3 full replace
    {1'b1, 4'd3,  8'h08, 32'h0,        8'hF0},  // R3
    {1'b1, 4'd5,  8'h88, 32'h0,        8'hF0},  // R5
    {1'b0, 4'd9,  8'hBC, 32'hFFFFFFFF, 8'h00},  // R9
    {1'b1, 4'd11, 8'h3C, 32'h0,        8'h00}   // R11 / R9
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk);
    // R1 during reset
    tick();
    check("R1 sel in reset", pad_gpio_sel, 32'h0);
    check("R1 oe in reset", pad_oe, 32'h0);
    tick();
    rst = 1'b0;
    tick();
    bus_read(8'h00, rd); check("R1 mode p0", rd, 32'h0);
    bus_read(8'h14, rd); check("R1 drven p1", rd, 32'h0);
    bus_read(8'h2C, rd); check("R1 level p3", rd, 32'h0);
    check("R1 sel", pad_gpio_sel, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) begin
        bus_read(VEC[i][47:40], rd);
        checks++;
        if (rd !== {24'h0, VEC[i][7:0]}) begin
          fails++;
          $display("FAIL R%0d vec %0d actual=%08h expected=%08h",
                   VEC[i][51:48], i, rd, {24'h0, VEC[i][7:0]});
        end
      end else begin
        bus_write(VEC[i][47:40], VEC[i][39:8]);
      end
    end

    // R10: no read, data returns to zero
    bus_read(8'h00, rd);
    tick();
    check("R10 idle rdata", bus_rdata, 32'h0);

    // R6 / R12: port 0 under GPIO control
    bus_write(8'h00, 32'hFF);
    bus_write(8'h10, 32'hFF);
    bus_write(8'h20, 32'h5A);
    tick();
    check("R6 pad_out p0", {24'h0, pad_out[7:0]}, 32'h5A);
    check("R6 pad_oe p0", {24'h0, pad_oe[7:0]}, 32'hFF);
    check("R12 sel p0", {24'h0, pad_gpio_sel[7:0]}, 32'hFF);

    // R7: upper half of port 0 handed to the alternate function
    alt_out = 32'hFFFF_FFFF;
    alt_oe  = 32'h0;
    bus_write(8'h80, 32'h0000F000);
    tick();
    check("R7 pad_out p0", {24'h0, pad_out[7:0]}, 32'hFA);
    check("R7 pad_oe p0", {24'h0, pad_oe[7:0]}, 32'h0F);
    check("R7 pad_oe p1 alt", {24'h0, pad_oe[15:8]}, 32'h00);
    check("R12 sel p0 split", {24'h0, pad_gpio_sel[7:0]}, 32'h0F);

    // R8: synchronizer latency, port 0 driven as output still reads pad
    pad_in = 32'h80402010;
    tick();
    bus_read(8'h30, rd); check("R8 one edge old", rd, 32'h0);
    bus_read(8'h30, rd); check("R8 port0 new", rd, 32'h10);
    bus_read(8'h3C, rd); check("R8 port3 new", rd, 32'h80);
    bus_read(8'h34, rd); check("R8 port1 new", rd, 32'h20);

    finish_run();
  end
endmodule